// File: doc/BRIEF.md
# Optimal-Filter Pulse Amplitude and Time Estimator

This block takes a stream of signed samples from a free-running converter and, when a trigger is accepted, estimates the amplitude and the fine arrival time of the pulse held in the most recent N samples. The frozen window is correlated against two weight tables. One table gives the amplitude for each of seven time phases (-3 to +3). The other gives a time product whose sign shows on which side of the current phase the peak lies.

A binary search over the phases is driven by the sign of the time product. The amplitudes at the chosen phase and its two neighbours are then fitted with a parabola. A short sequential divider produces the sub-phase offset, and the amplitude is corrected at the vertex.

Weights are loaded through a plain address/data/write-enable port while triggering is disabled. Triggers that arrive during a computation are dropped and counted as pile-up.

Top module: `pulse_opt_est`

## Requirements
- R1: After reset, `res_valid` is low, `res_amp`, `res_time` and `pileup_cnt` are zero, and the block waits for a trigger.
- R2: A sample enters the delay line only in a cycle with `smp_valid` high. An accepted trigger freezes the N samples held before that clock edge, and tap 0 is the oldest of them.
- R3: For phase p, A(p) and T(p) are the sums over taps k of sample k times the weight for (p,k). `coef_addr` bit 7 selects the table (0 amplitude, 1 time), bits 6:4 hold p+3 (value 7 is discarded), and bits 3:0 hold the tap.
- R4: The search visits phase 0 first. If T is nonzero it moves to +2 when T>0 or to -2 when T<0, and from there one step in the direction of the sign of T. It stops early at any phase where T is zero. The best phase p is the last phase visited.
- R5: When p is +3 or -3, `res_time` is 256·p and `res_amp` is A(p).
- R6: Otherwise, with a=A(p-1), b=A(p), c=A(p+1), num=a-c and den=2(a-2b+c), the offset f is as follows. f is 0 when den is 0. f is ±255 when |num|≥|den|, with the sign of num/den. In all other cases f is 256·num/den truncated toward zero. `res_time` is 256·p+f as a 12-bit two's-complement value.
- R7: `res_amp` is b − floor((a−c)·f/1024), kept to 40 bits.
- R8: Each accepted trigger gives exactly one `res_valid` pulse, one clock long.
- R9: A trigger (`trig` and `trig_en` both high) that arrives while a computation is in progress is dropped and adds one to `pileup_cnt`. A trigger with `trig_en` low is ignored and is not counted.
- R10: A coefficient write while `trig_en` is high has no effect on the tables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 14 | Signed sample |
| trig_en | input | 1 | Trigger enable; low opens coefficient writes |
| trig | input | 1 | Trigger request |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 8 | Table, phase and tap select |
| coef_data | input | 18 | Signed weight |
| res_valid | output | 1 | One-cycle result strobe |
| res_amp | output | 40 | Signed amplitude estimate |
| res_time | output | 12 | Signed time, 8 fraction bits, in phase units |
| pileup_cnt | output | 16 | Number of dropped triggers |

## Verification
The hardest path to reach is the divider saturation, where the curvature of the three amplitudes is small next to their slope. Random weights almost never produce it. Directed tables that are flat per phase and have tiny curvature around phase +1 force it. Other directed tables steer the search to each edge phase, hold the time product at zero on the first visit, and make the amplitudes linear so that the divisor is zero. Constrained random windows and weights cover the remaining search paths.

// File: rtl/pulse_opt_est.sv
module pulse_opt_est #(
  parameter int SW = 14,
  parameter int CW = 18,
  parameter int N  = 16,
  parameter int AW = 40,
  parameter int FB = 8,
  parameter int PW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic [SW-1:0]        smp_data,
  input  logic                 trig_en,
  input  logic                 trig,
  input  logic                 coef_we,
  input  logic [$clog2(N)+3:0] coef_addr,
  input  logic [CW-1:0]        coef_data,
  output logic                 res_valid,
  output logic [AW-1:0]        res_amp,
  output logic [FB+3:0]        res_time,
  output logic [PW-1:0]        pileup_cnt
);
  localparam int TB = $clog2(N);
  localparam int CA = TB + 4;
  localparam int TW = FB + 4;
  localparam int NP = 7;
  localparam int DW = AW + 4;
  localparam int RW = DW + 1;
  localparam int XW = DW + FB + 1;
  localparam int KB = $clog2(FB + 1);

  typedef enum logic [2:0] {IDLE, MAC, EVAL, DSET, DIV, FIN} st_t;
  st_t st;

  logic signed [SW-1:0] dly [N];
  logic signed [SW-1:0] win [N];
  logic signed [CW-1:0] wa [NP][N];
  logic signed [CW-1:0] wt [NP][N];

  logic signed [2:0] ph, best;
  logic [2:0] step;
  logic [TB-1:0] tap;
  logic [KB-1:0] dcnt;
  logic signed [AW-1:0] acc_a, acc_t, ab, alo, ahi;
  logic [RW-1:0] rem, dmag;
  logic [FB-1:0] quo;
  logic neg, fz;

  wire       take = trig && trig_en;
  wire [2:0] pidx = ph + 3'd3;
  wire [2:0] a_ph = coef_addr[CA-2 -: 3];
  wire signed [AW-1:0] pa = AW'(win[tap]) * AW'(wa[pidx][tap]);
  wire signed [AW-1:0] pt = AW'(win[tap]) * AW'(wt[pidx][tap]);

  wire signed [DW-1:0] nume = DW'(alo) - DW'(ahi);
  wire signed [DW-1:0] deno = (DW'(alo) - (DW'(ab) <<< 1) + DW'(ahi)) <<< 1;
  wire [DW-1:0] nabs = nume[DW-1] ? DW'(-nume) : nume;
  wire [DW-1:0] dabs = deno[DW-1] ? DW'(-deno) : deno;
  wire [RW-1:0] r2 = {rem[RW-2:0], 1'b0};
  wire qb = r2 >= dmag;

  wire signed [FB:0] fq = $signed({1'b0, quo});
  wire signed [FB:0] frac = fz ? '0 : (neg ? -fq : fq);
  wire signed [XW-1:0] corr = XW'(nume) * XW'(frac);
  wire signed [XW-1:0] csh = corr >>> (FB + 2);
  wire signed [AW-1:0] amp = ab - AW'(csh);
  wire signed [TW-1:0] tim = (TW'(best) <<< FB) + TW'(frac);

  always_ff @(posedge clk) begin
    if (smp_valid) begin
      for (int i = 0; i < N - 1; i++) dly[i] <= dly[i+1];
      dly[N-1] <= smp_data;
    end
    if (coef_we && !trig_en && a_ph < 3'(NP)) begin
      if (coef_addr[CA-1]) wt[a_ph][coef_addr[TB-1:0]] <= coef_data;
      else                 wa[a_ph][coef_addr[TB-1:0]] <= coef_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; res_valid <= 1'b0; res_amp <= '0; res_time <= '0; pileup_cnt <= '0;
      ph <= '0; best <= '0; step <= '0; tap <= '0; dcnt <= '0;
      acc_a <= '0; acc_t <= '0; ab <= '0; alo <= '0; ahi <= '0;
      rem <= '0; dmag <= '0; quo <= '0; neg <= 1'b0; fz <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (take && st != IDLE) pileup_cnt <= pileup_cnt + 1'b1;
      case (st)
        IDLE: if (take) begin
          win <= dly; ph <= '0; step <= '0; tap <= '0;
          acc_a <= '0; acc_t <= '0; fz <= 1'b0; quo <= '0; neg <= 1'b0;
          alo <= '0; ahi <= '0; st <= MAC;
        end
        MAC: begin
          acc_a <= acc_a + pa;
          acc_t <= acc_t + pt;
          tap <= tap + 1'b1;
          if (tap == TB'(N - 1)) st <= EVAL;
        end
        EVAL: begin
          tap <= '0; acc_a <= '0; acc_t <= '0; st <= MAC;
          if (step < 3'd3) begin
            ab <= acc_a; best <= ph;
            if (acc_t == '0 || step == 3'd2) begin
              if (ph == 3'sd3 || ph == -3'sd3) begin
                fz <= 1'b1; st <= FIN;
              end else begin
                ph <= ph - 3'sd1; step <= 3'd3;
              end
            end else begin
              step <= step + 3'd1;
              if (step == 3'd0) ph <= acc_t[AW-1] ? -3'sd2 : 3'sd2;
              else              ph <= acc_t[AW-1] ? ph - 3'sd1 : ph + 3'sd1;
            end
          end else if (step == 3'd3) begin
            alo <= acc_a; ph <= best + 3'sd1; step <= 3'd4;
          end else begin
            ahi <= acc_a; st <= DSET;
          end
        end
        DSET: begin
          neg <= nume[DW-1] ^ deno[DW-1];
          if (deno == '0) begin
            fz <= 1'b1; st <= FIN;
          end else if (nabs >= dabs) begin
            quo <= '1; st <= FIN;
          end else begin
            rem <= RW'(nabs); dmag <= RW'(dabs); quo <= '0; dcnt <= '0; st <= DIV;
          end
        end
        DIV: begin
          rem <= qb ? r2 - dmag : r2;
          quo <= {quo[FB-2:0], qb};
          dcnt <= dcnt + 1'b1;
          if (dcnt == KB'(FB - 1)) st <= FIN;
        end
        FIN: begin
          res_valid <= 1'b1; res_amp <= amp; res_time <= tim; st <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pulse_opt_est_chk.sv
module pulse_opt_est_chk #(
  parameter int FB = 8,
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trig,
  input logic          trig_en,
  input logic          res_valid,
  input logic [FB+3:0] res_time,
  input logic [PW-1:0] pileup_cnt
);
  localparam int LIM = 3 << FB;

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_pileup_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pileup_cnt != $past(pileup_cnt) |-> pileup_cnt == PW'($past(pileup_cnt) + 1'b1));

  assert_pileup_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pileup_cnt != $past(pileup_cnt) |-> $past(trig && trig_en));

  assert_time_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($signed(res_time) <= LIM && $signed(res_time) >= -LIM));
endmodule

bind pulse_opt_est pulse_opt_est_chk #(.FB(FB), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .trig_en(trig_en),
  .res_valid(res_valid), .res_time(res_time), .pileup_cnt(pileup_cnt)
);

// File: tb/pulse_opt_est_tb.sv
`timescale 1ns/1ps
module pulse_opt_est_tb;
  logic clk = 0, rst_n = 0;
  logic smp_valid = 0, trig_en = 1, trig = 0, coef_we = 0;
  logic [13:0] smp_data = '0;
  logic [7:0] coef_addr = '0;
  logic [17:0] coef_data = '0;
  logic res_valid;
  logic [39:0] res_amp;
  logic [11:0] res_time;
  logic [15:0] pileup_cnt;

  int nchk = 0, nfail = 0, cyc = 0;
  int bwa [7][16];
  int bwt [7][16];
  int hist [16];

  always #2.5 clk = ~clk;

  pulse_opt_est u_dut (.*);

  task automatic wrap_up();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cyc);
      wrap_up();
    end
  end

  task automatic check(bit ok, string req, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint dot(bit tsel, int p);
    longint s = 0;
    for (int k = 0; k < 16; k++)
      s += longint'(hist[k]) * longint'(tsel ? bwt[p+3][k] : bwa[p+3][k]);
    return s;
  endfunction

  function automatic void model(output longint amp, output int tim);
    int p = 0;
    longint t, a, b, c, num, den, f;
    for (int s = 0; s < 3; s++) begin
      t = dot(1, p);
      if (t == 0 || s == 2) break;
      if (s == 0) p = (t > 0) ? 2 : -2;
      else p = (t > 0) ? p + 1 : p - 1;
    end
    b = dot(0, p);
    if (p == 3 || p == -3) begin
      amp = b; tim = 256 * p; return;
    end
    a = dot(0, p - 1); c = dot(0, p + 1);
    num = a - c; den = 2 * (a - 2 * b + c);
    if (den == 0) f = 0;
    else if ((num < 0 ? -num : num) >= (den < 0 ? -den : den)) f = ((num < 0) ^ (den < 0)) ? -255 : 255;
    else f = (num * 256) / den;
    amp = b - ((num * f) >>> 10);
    tim = 256 * p + int'(f);
  endfunction

  task automatic push(int x);
    @(negedge clk); smp_valid = 1; smp_data = 14'(x);
    for (int k = 0; k < 15; k++) hist[k] = hist[k+1];
    hist[15] = x;
    @(negedge clk); smp_valid = 0; smp_data = 14'($urandom);
  endtask

  task automatic wcoef(bit tsel, int p, int k, int v, bit upd);
    @(negedge clk); coef_we = 1; coef_addr = {tsel, 3'(p + 3), 4'(k)}; coef_data = 18'(v);
    if (upd) begin
      if (tsel) bwt[p+3][k] = v; else bwa[p+3][k] = v;
    end
    @(negedge clk); coef_we = 0;
  endtask

  task automatic load_tables(int mode);
    trig_en = 0;
    for (int p = -3; p <= 3; p++)
      for (int k = 0; k < 16; k++) begin
        int va, vt;
        va = $urandom_range(0, 262143) - 131072;
        vt = $urandom_range(0, 262143) - 131072;
        case (mode)
          1: vt = 0;
          2: vt = 1;
          3: vt = -1;
          4: va = 1000 + 7 * k;
          5: begin va = (p == 0) ? 0 : (p == 1) ? 50 : (p == 2) ? 101 : 3;
                   vt = (p == 0) ? 1 : (p == 2) ? -1 : 0; end
          default: ;
        endcase
        wcoef(0, p, k, va, 1);
        wcoef(1, p, k, vt, 1);
      end
    @(negedge clk); trig_en = 1;
  endtask

  task automatic fill(int mode);
    for (int i = 0; i < 16; i++) push(mode == 0 ? $urandom_range(0, 16383) - 8192 : mode);
  endtask

  task automatic pulse(string req, int extra);
    longint ea; int et, n, p0;
    model(ea, et);
    p0 = int'(pileup_cnt);
    @(negedge clk); trig = 1;
    @(negedge clk); trig = 0;
    n = 0;
    while (!res_valid && n < 1000) begin
      @(negedge clk); n++;
      if (extra && n == 5) trig = 1;
      if (extra && n == 6) trig = 0;
    end
    check(res_valid, {req, " R8 result strobe"}, res_valid, 1);
    check(res_amp == ea[39:0], {req, " R7 amplitude"}, $signed(res_amp), ea);
    check(res_time == 12'(et), {req, " R6 time"}, $signed(res_time), et);
    @(negedge clk);
    check(!res_valid, "R8 strobe one cycle", res_valid, 0);
    if (extra) begin
      check(int'(pileup_cnt) == p0 + 1, "R9 pile-up count", pileup_cnt, p0 + 1);
      n = 0;
      while (!res_valid && n < 300) begin @(negedge clk); n++; end
      check(!res_valid, "R9 dropped trigger gives no result", res_valid, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < 16; k++) hist[k] = 0;
    repeat (4) @(negedge clk);
    check(!res_valid && res_amp == 0 && res_time == 0 && pileup_cnt == 0, "R1 reset state",
          {res_valid, res_amp[7:0]}, 0);
    rst_n = 1;

    load_tables(1); fill(0); pulse("R4 zero T at phase 0", 0);
    load_tables(2); fill(100); pulse("R5 edge +3", 0);
    check(res_time == 12'd768, "R5 time at +3", res_time, 768);
    load_tables(3); fill(100); pulse("R5 edge -3", 0);
    check($signed(res_time) == -768, "R5 time at -3", $signed(res_time), -768);
    load_tables(4); fill(0); pulse("R6 zero divisor", 0);
    check(res_time[7:0] == 0, "R6 zero divisor fraction", res_time[7:0], 0);
    load_tables(5); fill(1); pulse("R6 saturation", 0);

    load_tables(0); fill(0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); smp_valid = 0; smp_data = 14'($urandom);
    end
    pulse("R2 invalid samples ignored", 0);

    for (int i = 0; i < 4; i++)
      wcoef(i[0], i - 2, i, 12345, 0);
    pulse("R10 writes ignored while enabled", 0);

    begin
      int p0 = int'(pileup_cnt), n = 0;
      @(negedge clk); trig_en = 0; trig = 1;
      @(negedge clk); trig = 0;
      while (!res_valid && n < 300) begin @(negedge clk); n++; end
      check(!res_valid, "R9 disabled trigger ignored", res_valid, 0);
      check(int'(pileup_cnt) == p0, "R9 disabled trigger not counted", pileup_cnt, p0);
      trig_en = 1;
    end

    pulse("R9 pile-up", 1);

    for (int r = 0; r < 40; r++) begin
      if (r % 8 == 0) load_tables(0);
      fill(0);
      pulse("R3 R4 random", 0);
    end
    wrap_up();
  end
endmodule